// File: doc/BRIEF.md
# Address Window Register Bank and Decoder

This block holds the configuration for three address windows in a bank of 64-bit registers reached over a simple word-addressed register bus. Two memory windows are sized: each has a base register and a mask register, and the window size comes from the mask. The third window has a fixed 4 KiB size and only a base register. A single enable register turns each window on or off.

In the same clock, the block compares a physical address on its decode port against every enabled window. It reports whether the address hits, which window won, and the byte offset inside that window. Register writes are cut to the granularity that each register supports. An illegal access, a write to a register that does not exist, or a change to a window that is still enabled raises a one-cycle error pulse.

The reset contents of the base registers depend on two small strap inputs that identify the chip and the unit. This lets several instances come out of reset with windows that do not overlap.

Top module: `win_bar_decoder`

## Requirements
- R1: An access is legal only when `reg_size` is 8 and `reg_addr[2:0]` is 0. An illegal read or write stores nothing, returns zero data, and raises `reg_err` in the following cycle.
- R2: The register index is `reg_addr >> 3`. The indices are: 0 memory-window-0 base, 1 memory-window-0 mask, 2 memory-window-1 base, 3 memory-window-1 mask, 4 register-window base, 5 enable. A legal read returns the stored value in the cycle of the read strobe. Indices 6 and 7 read as zero and raise no error.
- R3: A legal write to index 0, 1, 2 or 3 stores only bits 63:30 of the write data and clears bits 29:0.
- R4: A legal write to index 4 stores only bits 63:26 of the write data.
- R5: A legal write to index 5 stores only bits 63:59. Bit 63 enables memory window 0, bit 62 enables memory window 1, and bit 61 enables the register window.
- R6: After reset, with chip number c and unit number u:
  - memory-window-0 base = (0x3d00000000000 + 0x4000000000·c + 0x1000000000·u) << 14
  - memory-window-1 base = (0x3ff8000000000 + 0x200000000·c + 0x80000000·u) << 14
  - register-window base = (0x3fffe40000000 + 0x400000·c + 0x100000·u) << 14
  - mask 0 = 0x3fff000000000 << 14
  - mask 1 = 0x3ffff80000000 << 14
  - enable = 0
- R7: For a memory window, the effective base is base >> 14 and the size is (~mask >> 14) + 1. An address hits when (addr & ~(size-1)) equals the effective base. The offset is addr & (size-1).
- R8: The register window has a size of 0x1000 bytes. Its effective base is base >> 14, and its offset is addr & 0xfff.
- R9: The window codes are 0 for memory window 0, 1 for memory window 1 and 2 for the register window. When several enabled windows hit, the register window wins, then memory window 0, then memory window 1. With no hit, `dec_hit`, `dec_win` and `dec_off` are all zero.
- R10: A legal write to indices 0 to 3 while enable bit 63 or 62 is set raises `reg_err`. A legal write to index 4 while enable bit 61 is set also raises `reg_err`. In both cases the write is still stored.
- R11: A legal write to index 6 or 7 raises `reg_err` and changes no register.
- R12: A change to the enable register affects the decode from the cycle after the write, not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_id | input | CHIP_W | Chip number strap, used for the reset bases |
| unit_id | input | UNIT_W | Unit number strap, used for the reset bases |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | RA_W | Byte address of the access |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data; the lowest-addressed byte is on bits 63:56 |
| reg_rdata | output | 64 | Read data, valid in the cycle of the read strobe |
| reg_err | output | 1 | Error pulse, one cycle after the offending access |
| dec_addr | input | PA_W | Physical address to decode |
| dec_hit | output | 1 | Address falls in an enabled window |
| dec_win | output | 2 | Code of the winning window |
| dec_off | output | PA_W | Byte offset inside the winning window |

## Verification
A corrupted base, mask or enable bit appears at the decode outputs as soon as an address is presented near that window. In the same cycle the hit flag, the window code or the offset departs from the reference, and a read of the register shows the bad value at once. A wrong error decision shows up exactly one cycle after the access. The reference model is compared every clock, so a fault appears no later than the first cycle that touches the state involved.

// File: rtl/win_bar_decoder.sv
module win_bar_decoder #(
  parameter int CHIP_W = 3,
  parameter int UNIT_W = 3,
  parameter int RA_W   = 6,
  parameter int PA_W   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic [UNIT_W-1:0] unit_id,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_err,
  input  logic [PA_W-1:0]   dec_addr,
  output logic              dec_hit,
  output logic [1:0]        dec_win,
  output logic [PA_W-1:0]   dec_off
);

  localparam int IDX_W = RA_W - 3;
  localparam int SHIFT = 14;
  localparam logic [IDX_W-1:0] IX_M0B = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_M0M = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_M1B = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_M1M = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_RWB = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_EN  = IDX_W'(5);
  localparam logic [63:0] KEEP_MEM = 64'hFFFF_FFFF_C000_0000;
  localparam logic [63:0] KEEP_RW  = 64'hFFFF_FFFF_FC00_0000;
  localparam logic [63:0] KEEP_EN  = 64'hF800_0000_0000_0000;
  localparam logic [63:0] RW_LIM   = 64'h0000_0000_0000_0FFF;
  localparam int EN_M0 = 63;
  localparam int EN_M1 = 62;
  localparam int EN_RW = 61;

  logic [63:0] m0_base, m0_mask, m1_base, m1_mask, rw_base, win_en;
  logic [63:0] chip64, unit64;
  logic [IDX_W-1:0] idx;
  logic acc_ok, idx_known, mem_guard, rw_guard, err_d;

  assign idx       = reg_addr[RA_W-1:3];
  assign acc_ok    = (reg_size == 4'd8) && (reg_addr[2:0] == 3'd0);
  assign idx_known = idx <= IX_EN;
  assign mem_guard = win_en[EN_M0] | win_en[EN_M1];
  assign rw_guard  = win_en[EN_RW];
  assign chip64    = 64'(chip_id);
  assign unit64    = 64'(unit_id);

  always_comb begin
    err_d = (reg_wr || reg_rd) && !acc_ok;
    if (reg_wr && acc_ok) begin
      if (!idx_known) err_d = 1'b1;
      else if (idx <= IX_M1M && mem_guard) err_d = 1'b1;
      else if (idx == IX_RWB && rw_guard) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m0_base <= (64'h3d00000000000 + 64'h4000000000 * chip64 + 64'h1000000000 * unit64) << SHIFT;
      m1_base <= (64'h3ff8000000000 + 64'h0200000000 * chip64 + 64'h0080000000 * unit64) << SHIFT;
      rw_base <= (64'h3fffe40000000 + 64'h0000400000 * chip64 + 64'h0000100000 * unit64) << SHIFT;
      m0_mask <= 64'h3fff000000000 << SHIFT;
      m1_mask <= 64'h3ffff80000000 << SHIFT;
      win_en  <= '0;
      reg_err <= 1'b0;
    end else begin
      reg_err <= err_d;
      if (reg_wr && acc_ok) begin
        case (idx)
          IX_M0B:  m0_base <= reg_wdata & KEEP_MEM;
          IX_M0M:  m0_mask <= reg_wdata & KEEP_MEM;
          IX_M1B:  m1_base <= reg_wdata & KEEP_MEM;
          IX_M1M:  m1_mask <= reg_wdata & KEEP_MEM;
          IX_RWB:  rw_base <= reg_wdata & KEEP_RW;
          IX_EN:   win_en  <= reg_wdata & KEEP_EN;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && acc_ok) begin
      case (idx)
        IX_M0B:  reg_rdata = m0_base;
        IX_M0M:  reg_rdata = m0_mask;
        IX_M1B:  reg_rdata = m1_base;
        IX_M1M:  reg_rdata = m1_mask;
        IX_RWB:  reg_rdata = rw_base;
        IX_EN:   reg_rdata = win_en;
        default: reg_rdata = '0;
      endcase
    end
  end

  logic [63:0] pa64, m0_size, m1_size, m0_lim, m1_lim;
  logic m0_hit, m1_hit, rw_hit;

  assign pa64    = 64'(dec_addr);
  assign m0_size = (~m0_mask >> SHIFT) + 64'd1;
  assign m1_size = (~m1_mask >> SHIFT) + 64'd1;
  assign m0_lim  = m0_size - 64'd1;
  assign m1_lim  = m1_size - 64'd1;
  assign m0_hit  = win_en[EN_M0] && ((pa64 & ~m0_lim) == (m0_base >> SHIFT));
  assign m1_hit  = win_en[EN_M1] && ((pa64 & ~m1_lim) == (m1_base >> SHIFT));
  assign rw_hit  = win_en[EN_RW] && ((pa64 & ~RW_LIM) == (rw_base >> SHIFT));

  always_comb begin
    dec_hit = 1'b1;
    dec_win = 2'd0;
    dec_off = '0;
    if (rw_hit) begin
      dec_win = 2'd2;
      dec_off = PA_W'(pa64 & RW_LIM);
    end else if (m0_hit) begin
      dec_win = 2'd0;
      dec_off = PA_W'(pa64 & m0_lim);
    end else if (m1_hit) begin
      dec_win = 2'd1;
      dec_off = PA_W'(pa64 & m1_lim);
    end else begin
      dec_hit = 1'b0;
    end
  end

  AST_BAD_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) && !acc_ok |=> reg_err); // R1
  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !acc_ok |=> $stable(m0_base) && $stable(m0_mask) && $stable(m1_base)
                          && $stable(m1_mask) && $stable(rw_base) && $stable(win_en)); // R1
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !idx_known |-> reg_rdata == 64'd0); // R2
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    win_en[63:61] == 3'd0 |-> !dec_hit); // R5
  AST_RW_OFF_4K: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit && dec_win == 2'd2 |-> dec_off < PA_W'(4096)); // R8
  AST_REPROG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && acc_ok && idx == IX_RWB && win_en[EN_RW] |=> reg_err); // R10
  AST_UNKNOWN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && acc_ok && !idx_known |=> reg_err && $stable(win_en)); // R11

endmodule

// File: tb/tb_win_bar_decoder.sv
module tb_win_bar_decoder;
  localparam int CHIP_W = 3;
  localparam int UNIT_W = 3;
  localparam int RA_W   = 6;
  localparam int PA_W   = 50;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CHIP_W-1:0] chip_id = 3'd3;
  logic [UNIT_W-1:0] unit_id = 3'd1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [3:0] reg_size = 4'd8;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic reg_err;
  logic [PA_W-1:0] dec_addr = '0;
  logic dec_hit;
  logic [1:0] dec_win;
  logic [PA_W-1:0] dec_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_bar_decoder #(.CHIP_W(CHIP_W), .UNIT_W(UNIT_W), .RA_W(RA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .unit_id(unit_id),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .dec_addr(dec_addr), .dec_hit(dec_hit), .dec_win(dec_win), .dec_off(dec_off));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R6";
  logic [63:0] mr [6];
  bit err_q;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    logic [63:0] c = 64'(chip_id);
    logic [63:0] u = 64'(unit_id);
    mr[0] = (64'h3d00000000000 + c * 64'h4000000000 + u * 64'h1000000000) << 14;
    mr[1] = 64'h3fff000000000 << 14;
    mr[2] = (64'h3ff8000000000 + c * 64'h200000000 + u * 64'h80000000) << 14;
    mr[3] = 64'h3ffff80000000 << 14;
    mr[4] = (64'h3fffe40000000 + c * 64'h400000 + u * 64'h100000) << 14;
    mr[5] = 64'd0;
    err_q = 1'b0;
  endtask

  function automatic logic [63:0] win_base(int id);
    return (id == 0 ? mr[0] : id == 1 ? mr[2] : mr[4]) >> 14;
  endfunction

  function automatic logic [63:0] win_lim(int id);
    if (id == 2) return 64'hfff;
    return (~(id == 0 ? mr[1] : mr[3])) >> 14;
  endfunction

  task automatic exp_dec(input logic [PA_W-1:0] pa, output logic hit,
                         output logic [1:0] w, output logic [63:0] off);
    logic [63:0] a = 64'(pa);
    hit = 1'b0; w = 2'd0; off = 64'd0;
    for (int k = 0; k < 3; k++) begin
      int id = (k == 0) ? 2 : (k == 1) ? 0 : 1;
      bit en = mr[5][63 - (id == 0 ? 0 : id == 1 ? 1 : 2)];
      if (!hit && en && ((a & ~win_lim(id)) == win_base(id))) begin
        hit = 1'b1; w = 2'(id); off = 64'(PA_W'(a & win_lim(id)));
      end
    end
  endtask

  task automatic cyc(bit wr, bit rd, int unsigned addr, logic [3:0] sz,
                     logic [63:0] wd, logic [PA_W-1:0] pa);
    logic ehit; logic [1:0] ew; logic [63:0] eoff, erd;
    bit ok; int idx; bit e;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = RA_W'(addr); reg_size = sz;
    reg_wdata = wd; dec_addr = pa;
    #1;
    ok  = (sz == 4'd8) && (addr % 8 == 0);
    idx = int'(addr / 8);
    erd = (rd && ok && idx <= 5) ? mr[idx] : 64'd0;
    exp_dec(pa, ehit, ew, eoff);
    chk("rdata", reg_rdata, erd);
    chk("hit", 64'(dec_hit), 64'(ehit));
    chk("win", 64'(dec_win), 64'(ew));
    chk("off", 64'(dec_off), eoff);
    chk("err", 64'(reg_err), 64'(err_q));
    @(posedge clk);
    e = (wr || rd) && !ok;
    if (wr && ok) begin
      if (idx > 5) e = 1'b1;
      else if (idx <= 3 && (mr[5][63] || mr[5][62])) e = 1'b1;
      else if (idx == 4 && mr[5][61]) e = 1'b1;
      if (idx <= 3) mr[idx] = wd & 64'hFFFF_FFFF_C000_0000;
      else if (idx == 4) mr[idx] = wd & 64'hFFFF_FFFF_FC00_0000;
      else if (idx == 5) mr[idx] = wd & 64'hF800_0000_0000_0000;
    end
    err_q = e;
  endtask

  task automatic wr8(int i, logic [63:0] d, logic [PA_W-1:0] pa = '0);
    cyc(1, 0, i * 8, 4'd8, d, pa);
  endtask
  task automatic rd8(int i, logic [PA_W-1:0] pa = '0);
    cyc(0, 1, i * 8, 4'd8, 64'd0, pa);
  endtask
  task automatic look(logic [PA_W-1:0] pa);
    cyc(0, 0, 0, 4'd8, 64'd0, pa);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    cur_req = "watchdog";
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] b0, b1, bw;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R6";
    for (int i = 0; i < 6; i++) rd8(i);
    cur_req = "R2";
    rd8(6); rd8(7);

    b0 = win_base(0); b1 = win_base(1); bw = win_base(2);
    cur_req = "R12";
    look(PA_W'(b0));
    cyc(1, 0, 40, 4'd8, 64'h8000_0000_0000_1234, PA_W'(b0));
    look(PA_W'(b0));
    cur_req = "R5";
    rd8(5);
    cur_req = "R7";
    look(PA_W'(b0 + 64'h1234_5678));
    look(PA_W'(b0 + win_lim(0)));
    look(PA_W'(b0 + win_lim(0) + 1));
    look(PA_W'(b0 - 1));

    cur_req = "R10";
    wr8(0, b0 << 14);
    rd8(0);
    wr8(5, 64'd0);
    cur_req = "R3";
    wr8(0, (b0 << 14) | 64'h0000_0000_3FFF_FFFF);
    wr8(3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd8(0); rd8(3);
    wr8(3, 64'h3ffff80000000 << 14);
    cur_req = "R4";
    bw = b0 + 64'h1000_0000;
    wr8(4, (bw << 14) | 64'h3FF_FFFF);
    rd8(4);
    b1 = b0 + 64'h8000_0000;
    wr8(2, b1 << 14);

    cur_req = "R9";
    wr8(5, 64'hE000_0000_0000_0000);
    look(PA_W'(bw + 64'h10));
    look(PA_W'(bw + 64'h1000));
    look(PA_W'(b1 + 64'h20));
    wr8(5, 64'h6000_0000_0000_0000);
    look(PA_W'(b1 + 64'h20));
    cur_req = "R8";
    look(PA_W'(bw + 64'hfff));
    look(PA_W'(bw + 64'h1000));
    cur_req = "R10";
    wr8(4, 64'd0);
    rd8(4);
    wr8(5, 64'd0);

    cur_req = "R1";
    cyc(1, 0, 40, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    cyc(0, 1, 0, 4'd2, 64'd0, '0);
    cyc(1, 0, 41, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    cyc(0, 1, 3, 4'd8, 64'd0, '0);
    rd8(5);
    cur_req = "R11";
    wr8(6, 64'hFFFF_FFFF_FFFF_FFFF);
    wr8(7, 64'h1234);
    rd8(5); rd8(7);

    cur_req = "R7";
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 10);
      int id = int'($urandom % 3);
      logic [63:0] rnd = {$urandom, $urandom};
      logic [PA_W-1:0] pa = PA_W'(win_base(id) + (rnd & ((win_lim(id) << 1) | 64'd1)));
      if (op == 0) cyc(1, 0, ($urandom % 8) * 8, 4'd8, {$urandom, $urandom}, pa);
      else if (op == 1) cyc(1, 0, 40, 4'd8, {5'($urandom), 59'd0}, pa);
      else if (op == 2) cyc(0, 1, ($urandom % 8) * 8, 4'd8, 64'd0, pa);
      else if (op == 3) cyc($urandom % 2 == 0, 1, $urandom % 64, 4'($urandom), 64'd0, pa);
      else look(pa);
    end
    look('0);
    finish_run();
  end
endmodule